// File: doc/BRIEF.md
# Three-Lane 7:1 Parallel Serializer

This block turns a 21-bit parallel word into three serial data lanes and one framing lane. A single bit clock runs at seven times the word rate. A one-in-seven word strobe marks the bit-clock cycle in which the parallel word is sampled. The seven bit-clock cycles that follow a strobe form the seven bit slots of one word period.

Each data lane carries one 7-bit slice of the word, least significant bit first. The framing lane repeats a fixed 7-slot pattern that marks word boundaries for the receiver. A captured word starts to leave the block exactly one word period after the strobe that sampled it. An active-low power-down input disables the outputs at once. After power-down is released, the outputs come back only at a word boundary, and only after one full word period.

Top module: `tri_lane_serializer`

## Requirements
- R1: On every bit-clock edge with `word_stb` high, all 21 bits of `din` are captured. Values on `din` at edges without the strobe never reach the lanes.
- R2: In continuous operation, bit 0 of each lane for a word captured at strobe edge S appears in the bit-clock cycle that follows the next strobe edge (S + 7 cycles).
- R3: `lane_q[k]` carries `din` bits 7k to 7k+6. Lane 0 carries bits 0-6, lane 1 carries bits 7-13 and lane 2 carries bits 14-20.
- R4: Each lane sends its slice least significant bit first, one bit per bit-clock cycle. Slot i (i = 0..6 after the load edge) carries bit 7k+i.
- R5: While enabled, `frame_q` sends 1,1,0,0,0,1,1 in slots 0 to 6 of every word period, so slot 0 is always high.
- R6: From the first edge at which `pwr_n` is sampled low, `oe` is 0 and `lane_q` and `frame_q` are 0. This holds for as long as the block is disabled.
- R7: After `pwr_n` returns high, the first strobe edge arms the block and does not enable it. `oe` rises only at the following strobe edge. The first word sent is the one captured at the arming strobe.
- R8: Synchronous active-high `rst` clears `oe` and all lane outputs, and leaves the block unarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the word rate |
| rst | input | 1 | Synchronous active-high reset |
| word_stb | input | 1 | One-in-seven strobe marking the word sampling cycle |
| din | input | 21 | Parallel input word |
| pwr_n | input | 1 | Active-low power-down |
| lane_q | output | 3 | Serial data lanes |
| frame_q | output | 1 | Framing lane |
| oe | output | 1 | Output enable (low models the high-impedance state) |

## Verification
The bench places junk on `din` in every non-strobe cycle. A design that sampled the word late or continuously would then send the wrong bits. Per-lane walking patterns and alternating patterns expose swapped lanes and reversed bit order. A design off by one cycle in latency would shift every slot and misplace the framing pattern.

Power-down is dropped partway through a word, held across whole words, and then released. The bench checks that a design which re-enables at once, or which sends a stale word captured before power-down, fails on `oe` or on the first word sent after release.

// File: rtl/ser7_pkg.sv
package ser7_pkg;
  localparam int unsigned SLOTS_DEF = 7;
  localparam int unsigned LANES_DEF = 3;
  // slot order: bit 0 goes out first
  localparam logic [SLOTS_DEF-1:0] FRAME_DEF = 7'b1100011;
endpackage

// File: rtl/ser7_capture.sv
module ser7_capture #(
  parameter int unsigned W = 21
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic [W-1:0] cap
);
  // data path register, no reset needed
  always_ff @(posedge clk) begin
    if (stb) cap <= din;
  end

  // R1: word sampled only on strobe edges
  a_r1_capture_on_strobe: assert property (@(posedge clk) disable iff (rst)
    stb |=> cap == $past(din));
  a_r1_hold_between: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(cap));
endmodule

// File: rtl/ser7_pwr_ctrl.sv
module ser7_pwr_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic pwr_n,
  output logic load,
  output logic clr,
  output logic oe
);
  logic armed;

  assign load = stb & pwr_n & armed;
  assign clr  = ~pwr_n | (stb & ~armed);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      oe    <= 1'b0;
    end else if (!pwr_n) begin
      armed <= 1'b0;
      oe    <= 1'b0;
    end else if (stb) begin
      armed <= 1'b1;
      oe    <= armed;
    end
  end

  // R6: power-down removes enable on the next edge
  a_r6_pd_disables: assert property (@(posedge clk) disable iff (rst)
    !pwr_n |=> !oe);
  // R7: enable only rises at a word boundary after arming
  a_r7_rise_on_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(stb) && $past(armed));
  a_r7_load_enables: assert property (@(posedge clk) disable iff (rst)
    load |=> oe);
endmodule

// File: rtl/ser7_piso.sv
module ser7_piso #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         clr,
  input  logic [N-1:0] pdata,
  output logic         q
);
  logic [N-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clr) sh <= '0;
    else if (load)  sh <= pdata;
    else            sh <= sh >> 1;
  end

  assign q = sh[0];

  // R4: first two slots leave in LSB-first order
  a_r4_slot0: assert property (@(posedge clk) disable iff (rst)
    load && !clr |=> q == $past(pdata[0]));
  a_r4_slot1: assert property (@(posedge clk) disable iff (rst)
    load && !clr ##1 !load && !clr |=> q == $past(pdata[1], 2));
  // R6: cleared lane is quiet
  a_r6_clear_quiet: assert property (@(posedge clk) disable iff (rst)
    clr |=> !q);
endmodule

// File: rtl/tri_lane_serializer.sv
module tri_lane_serializer
  import ser7_pkg::*;
#(
  parameter int unsigned SLOTS = SLOTS_DEF,
  parameter int unsigned LANES = LANES_DEF,
  parameter logic [SLOTS-1:0] FRAME_PAT = FRAME_DEF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   word_stb,
  input  logic [LANES*SLOTS-1:0] din,
  input  logic                   pwr_n,
  output logic [LANES-1:0]       lane_q,
  output logic                   frame_q,
  output logic                   oe
);
  localparam int unsigned WORD_W = LANES * SLOTS;

  logic [WORD_W-1:0] cap;
  logic              load;
  logic              clr;

  ser7_capture #(.W(WORD_W)) u_cap (
    .clk(clk), .rst(rst), .stb(word_stb), .din(din), .cap(cap)
  );

  ser7_pwr_ctrl u_pwr (
    .clk(clk), .rst(rst), .stb(word_stb), .pwr_n(pwr_n),
    .load(load), .clr(clr), .oe(oe)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ser7_piso #(.N(SLOTS)) u_lane (
      .clk(clk), .rst(rst), .load(load), .clr(clr),
      .pdata(cap[k*SLOTS +: SLOTS]), .q(lane_q[k])
    );
  end

  ser7_piso #(.N(SLOTS)) u_frame (
    .clk(clk), .rst(rst), .load(load), .clr(clr),
    .pdata(FRAME_PAT), .q(frame_q)
  );

  // R5: every transmitted word period opens with a high framing slot
  a_r5_frame_slot0: assert property (@(posedge clk) disable iff (rst)
    load |=> frame_q && oe);
  // R6: disabled outputs stay quiet
  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !oe |-> lane_q == '0 && !frame_q);
  // R8: reset leaves the block disabled
  a_r8_reset_off: assert property (@(posedge clk)
    rst |=> !oe);
endmodule

// File: tb/tri_lane_serializer_tb.sv
module tri_lane_serializer_tb;
  localparam logic [6:0] PAT = 7'b1100011;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        stb = 1'b0;
  logic        pwr_n = 1'b1;
  logic [20:0] din = '0;
  logic [2:0]  lane_q;
  logic        frame_q;
  logic        oe;

  tri_lane_serializer u_dut (
    .clk(clk), .rst(rst), .word_stb(stb), .din(din), .pwr_n(pwr_n),
    .lane_q(lane_q), .frame_q(frame_q), .oe(oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit running = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver-side model: pushes expected words into the scoreboard
  logic [20:0] q[$];
  logic [20:0] m_cap;
  bit m_armed = 1'b0;
  bit ev_load, ev_off;

  always @(posedge clk) begin
    ev_load = 1'b0;
    ev_off  = 1'b0;
    if (rst) begin
      m_armed = 1'b0;
      ev_off  = 1'b1;
      q.delete();
    end else if (!pwr_n) begin
      m_armed = 1'b0;
      ev_off  = 1'b1;
      if (stb) m_cap = din;
    end else if (stb) begin
      if (m_armed) begin
        q.push_back(m_cap);
        ev_load = 1'b1;
      end else begin
        ev_off = 1'b1;
      end
      m_armed = 1'b1;
      m_cap   = din;
    end
  end

  // monitor: pops and compares slot by slot
  bit active = 1'b0;
  int slot = 0;
  logic [20:0] cur, asm_w;

  always @(negedge clk) begin
    if (running) begin
      if (ev_off) active = 1'b0;
      if (ev_load) begin
        cur = q.pop_front();
        active = 1'b1;
        slot = 0;
        asm_w = '0;
      end
      if (active && slot < 7) begin
        chk(oe == 1'b1, "R7", int'(oe), 1);
        for (int k = 0; k < 3; k++) begin
          chk(lane_q[k] == cur[k*7+slot], (slot == 0) ? "R2" : "R4",
              int'(lane_q[k]), int'(cur[k*7+slot]));
          asm_w[k*7+slot] = lane_q[k];
        end
        chk(frame_q == PAT[slot], "R5", int'(frame_q), int'(PAT[slot]));
        slot++;
        if (slot == 7) begin
          for (int k = 0; k < 3; k++)
            chk(asm_w[k*7 +: 7] == cur[k*7 +: 7], "R3",
                int'(asm_w[k*7 +: 7]), int'(cur[k*7 +: 7]));
          chk(asm_w == cur, "R1", int'(asm_w), int'(cur));
        end
      end else if (!active) begin
        chk(oe == 1'b0, "R6", int'(oe), 0);
        chk(lane_q == 3'b000 && frame_q == 1'b0, "R6",
            int'({frame_q, lane_q}), 0);
      end
    end
  end

  // one word period: strobe in slot 0, junk on din elsewhere
  task automatic send_word(input logic [20:0] w, input bit pn, input int pd_at);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      stb   = (i == 0);
      din   = (i == 0) ? w : 21'($urandom);
      pwr_n = (i >= pd_at) ? 1'b0 : pn;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(oe == 1'b0, "R8", int'(oe), 0);
    chk(lane_q == 3'b000, "R8", int'(lane_q), 0);
    chk(frame_q == 1'b0, "R8", int'(frame_q), 0);
    running = 1'b1;
    rst = 1'b0;
    // first word after reset only arms (R7)
    send_word(21'h12345, 1'b1, 7);
    send_word(21'h1FFFFF, 1'b1, 7);
    send_word(21'h000000, 1'b1, 7);
    send_word(21'h155555, 1'b1, 7);
    send_word(21'h0AAAAA, 1'b1, 7);
    send_word(21'h00007F, 1'b1, 7);   // lane 0 only
    send_word(21'h003F80, 1'b1, 7);   // lane 1 only
    send_word(21'h1FC000, 1'b1, 7);   // lane 2 only
    for (int i = 0; i < 7; i++) send_word(21'(21'h1 << (i * 3)), 1'b1, 7);
    for (int i = 0; i < 4; i++) send_word(21'($urandom), 1'b1, 7);
    // power-down mid-word, then a full word down (R6)
    send_word(21'h0F0F0F, 1'b1, 3);
    send_word(21'h1E1E1E, 1'b0, 7);
    send_word(21'h1AAAAA, 1'b0, 7);
    // release: arm word, then enabled (R7)
    send_word(21'h13579B, 1'b1, 7);
    send_word(21'h02468A, 1'b1, 7);
    for (int i = 0; i < 4; i++) send_word(21'($urandom), 1'b1, 7);
    send_word(21'h000001, 1'b1, 7);
    @(negedge clk);
    running = 1'b0;
    stb = 1'b0;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule